// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the target (slave) side of a two-wire serial bus controller. It watches the synchronised SCL and SDA lines for a START condition and shifts in the address byte that follows. It then compares the seven address bits with a programmed own address, and the whole byte with the general-call address 0x00. When either one matches it acknowledges the byte on its own and tells the host which address hit. After that it moves data bytes between the bus and a single data register, in the direction given by the read/write bit.

The host reaches the block through a small register port. Reads are combinational. Writes and read side effects take place at the clock edge. Whenever a data byte is waiting for the host, the block holds SCL low until the host reads the byte or supplies the next one. A repeated START in the middle of a transfer runs the address match again. A STOP seen while the block is addressed sets a sticky flag that the host clears by writing a one to it. The bus lines are open-drain, and the block only reports when it pulls each line low.

Top module: `i2c_tgt_matcher`

## Requirements
- R1: Register offsets are 0 data, 1 status, 2 line status, 3 control, 4 own address. Own address bit 7 enables matching and bits 6:0 hold the address. An address byte whose upper seven bits equal the enabled own address is acknowledged by pulling SDA low. On that match, status bit 2 (new match) is set, line-status bit 2 (own hit) and bit 0 (module busy) are set, and status bit 0 (transmit) takes the byte's read/write bit.
- R2: Control bit 1 enables general call. With it set, the address byte 0x00 is acknowledged, line-status bit 3 (general-call hit) is set, and the transfer is a receive (status bit 0 clear). With it clear, 0x00 is not acknowledged.
- R3: With own-address bit 7 clear, the own address does not match and the address byte is not acknowledged.
- R4: An address byte that matches nothing is not acknowledged. The block then stays idle with SDA and SCL released and module busy clear, and it ignores every later byte until the next START.
- R5: irq_o is high while status bit 2 and control bit 0 (new-match interrupt enable) are both set. Writing a one to status bit 2 clears it.
- R6: In receive mode each byte is shifted in MSB first. After the eighth bit, status bit 4 (data pending) is set and SCL is held low. A read of the data register returns the byte, releases SCL and acknowledges it.
- R7: In transmit mode, after the address acknowledge and after every byte the master acknowledges, SCL is held low with data pending set. A write to the data register releases SCL, and the byte is driven MSB first.
- R8: A NACK from the master after a transmitted byte sets status bit 1. The block then releases SDA and stops driving until the next START or STOP.
- R9: A repeated START while addressed runs the address match again and sets new match again. No slave-stop flag is set at that point.
- R10: A STOP while addressed sets status bit 3 (slave stop, cleared by writing a one) and clears module busy and both hit bits. A STOP while not addressed leaves status bit 3 clear.
- R11: Line-status bit 1 (bus busy) is set by a START and cleared by a STOP.
- R12: Line-status bits 4 and 5 read the synchronised SDA and SCL levels. After reset every status flag is clear, no line is pulled low and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives the read side effects) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | Pull SCL low (clock stretch) |
| sda_pull_o | output | 1 | Pull SDA low |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, and therefore a 7-bit address, with a two-stage line synchroniser. It drives the bus with quarter-bit phases of ten clocks. At that rate whole transfers fit in a short run, including clock stretching on both receive and transmit, repeated START into the opposite direction, a master NACK, and STOP conditions seen both while addressed and while not. The behavioural bus and host model in the bench tracks the expected flags, and every bus phase is compared against it.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX_BYTE, ST_RX_HOLD, ST_RX_ACK,
    ST_TX_HOLD, ST_TX_BYTE, ST_TX_ACK, ST_SKIP
  } tgt_state_e;

  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_LINE = 2;
  localparam int OFS_CTRL = 3;
  localparam int OFS_OWN  = 4;
endpackage

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_sync[SYNC_STAGES-1];
      sda_q    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_o   = scl_sync[SYNC_STAGES-1];
  assign sda_o   = sda_sync[SYNC_STAGES-1];
  assign start_o = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;
  assign rise_o  = scl_o & ~scl_q;
  assign fall_o  = ~scl_o & scl_q;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              pending_o,
  output logic              xmit_o,
  output logic              addressed_o,
  output logic              bus_busy_o,
  output logic              own_hit_o,
  output logic              gc_hit_o,
  output logic              ev_match_o,
  output logic              ev_stop_o,
  output logic              ev_nack_o,
  output logic              scl_pull_o,
  output logic              sda_pull_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  tgt_state_e        state;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              acked;
  logic              own_ok, gc_ok;

  assign own_ok = own_addr_i[DATA_W-1] && (sh[DATA_W-1:1] == own_addr_i[DATA_W-2:0]);
  assign gc_ok  = gc_en_i && (sh == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      sh          <= '0;
      cnt         <= '0;
      acked       <= 1'b0;
      rx_data_o   <= '0;
      pending_o   <= 1'b0;
      xmit_o      <= 1'b0;
      addressed_o <= 1'b0;
      bus_busy_o  <= 1'b0;
      own_hit_o   <= 1'b0;
      gc_hit_o    <= 1'b0;
      ev_match_o  <= 1'b0;
      ev_stop_o   <= 1'b0;
      ev_nack_o   <= 1'b0;
      scl_pull_o  <= 1'b0;
      sda_pull_o  <= 1'b0;
    end else begin
      ev_match_o <= 1'b0;
      ev_stop_o  <= 1'b0;
      ev_nack_o  <= 1'b0;
      if (start_i) begin
        // addressed stays until the new address byte is judged
        state      <= ST_ADDR;
        cnt        <= '0;
        sh         <= '0;
        scl_pull_o <= 1'b0;
        sda_pull_o <= 1'b0;
        pending_o  <= 1'b0;
        own_hit_o  <= 1'b0;
        gc_hit_o   <= 1'b0;
        bus_busy_o <= 1'b1;
      end else if (stop_i) begin
        ev_stop_o   <= addressed_o;
        state       <= ST_IDLE;
        addressed_o <= 1'b0;
        own_hit_o   <= 1'b0;
        gc_hit_o    <= 1'b0;
        xmit_o      <= 1'b0;
        pending_o   <= 1'b0;
        scl_pull_o  <= 1'b0;
        sda_pull_o  <= 1'b0;
        bus_busy_o  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (rise_i) begin
              sh  <= {sh[DATA_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (fall_i && cnt == FULL) begin
              if (own_ok) begin
                own_hit_o   <= 1'b1;
                xmit_o      <= sh[0];
                addressed_o <= 1'b1;
                ev_match_o  <= 1'b1;
                sda_pull_o  <= 1'b1;
                state       <= ST_ADDR_ACK;
              end else if (gc_ok) begin
                gc_hit_o    <= 1'b1;
                xmit_o      <= 1'b0;
                addressed_o <= 1'b1;
                ev_match_o  <= 1'b1;
                sda_pull_o  <= 1'b1;
                state       <= ST_ADDR_ACK;
              end else begin
                addressed_o <= 1'b0;
                xmit_o      <= 1'b0;
                state       <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (fall_i) begin
              sda_pull_o <= 1'b0;
              cnt        <= '0;
              if (xmit_o) begin
                pending_o  <= 1'b1;
                scl_pull_o <= 1'b1;
                state      <= ST_TX_HOLD;
              end else begin
                state <= ST_RX_BYTE;
              end
            end
          end
          ST_RX_BYTE: begin
            if (rise_i) begin
              sh  <= {sh[DATA_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (fall_i && cnt == FULL) begin
              rx_data_o  <= sh;
              pending_o  <= 1'b1;
              scl_pull_o <= 1'b1;
              state      <= ST_RX_HOLD;
            end
          end
          ST_RX_HOLD: begin
            if (data_rd_i) begin
              pending_o  <= 1'b0;
              scl_pull_o <= 1'b0;
              sda_pull_o <= 1'b1;
              state      <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: begin
            if (fall_i) begin
              sda_pull_o <= 1'b0;
              cnt        <= '0;
              state      <= ST_RX_BYTE;
            end
          end
          ST_TX_HOLD: begin
            if (data_wr_i) begin
              sh         <= wdata_i;
              sda_pull_o <= ~wdata_i[DATA_W-1];
              pending_o  <= 1'b0;
              scl_pull_o <= 1'b0;
              cnt        <= '0;
              state      <= ST_TX_BYTE;
            end
          end
          ST_TX_BYTE: begin
            if (fall_i) begin
              if (cnt == LAST) begin
                sda_pull_o <= 1'b0;
                acked      <= 1'b0;
                state      <= ST_TX_ACK;
              end else begin
                sh         <= {sh[DATA_W-2:0], 1'b0};
                sda_pull_o <= ~sh[DATA_W-2];
                cnt        <= cnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (rise_i) begin
              acked <= ~sda_i;
            end else if (fall_i) begin
              if (acked) begin
                pending_o  <= 1'b1;
                scl_pull_o <= 1'b1;
                state      <= ST_TX_HOLD;
              end else begin
                ev_nack_o <= 1'b1;
                state     <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              pending_i,
  input  logic              xmit_i,
  input  logic              addressed_i,
  input  logic              bus_busy_i,
  input  logic              own_hit_i,
  input  logic              gc_hit_i,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              ev_match_i,
  input  logic              ev_stop_i,
  input  logic              ev_nack_i,
  output logic [DATA_W-1:0] own_addr_o,
  output logic              gc_en_o,
  output logic              nm_ie_o,
  output logic              new_match_o,
  output logic              data_wr_o,
  output logic              data_rd_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              stop_q, nack_q;
  logic              hit_data, hit_stat, hit_ctrl, hit_own;

  assign hit_data = addr_i == REG_AW'(OFS_DATA);
  assign hit_stat = addr_i == REG_AW'(OFS_STAT);
  assign hit_ctrl = addr_i == REG_AW'(OFS_CTRL);
  assign hit_own  = addr_i == REG_AW'(OFS_OWN);

  assign data_wr_o = wr_i & hit_data;
  assign data_rd_o = rd_i & hit_data;
  assign nm_ie_o   = ctrl_q[0];
  assign gc_en_o   = ctrl_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      own_addr_o  <= '0;
      new_match_o <= 1'b0;
      stop_q      <= 1'b0;
      nack_q      <= 1'b0;
    end else begin
      if (wr_i && hit_ctrl) ctrl_q <= wdata_i;
      if (wr_i && hit_own)  own_addr_o <= wdata_i;
      // set wins over a clearing write in the same cycle
      if (ev_match_i)                        new_match_o <= 1'b1;
      else if (wr_i && hit_stat && wdata_i[2]) new_match_o <= 1'b0;
      if (ev_stop_i)                         stop_q <= 1'b1;
      else if (wr_i && hit_stat && wdata_i[3]) stop_q <= 1'b0;
      if (ev_nack_i)                         nack_q <= 1'b1;
      else if (wr_i && hit_stat && wdata_i[1]) nack_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_AW'(OFS_DATA): rdata_o = rx_data_i;
      REG_AW'(OFS_STAT): rdata_o[4:0] = {pending_i, stop_q, new_match_o, nack_q, xmit_i};
      REG_AW'(OFS_LINE): rdata_o[5:0] = {scl_lvl_i, sda_lvl_i, gc_hit_i, own_hit_i,
                                         bus_busy_i, addressed_i};
      REG_AW'(OFS_CTRL): rdata_o = ctrl_q;
      REG_AW'(OFS_OWN):  rdata_o = own_addr_o;
      default:           rdata_o = '0;
    endcase
  end

  assign irq_o = (ctrl_q[0] & new_match_o) |
                 (ctrl_q[2] & (stop_q | nack_q | pending_i));
endmodule

// File: rtl/i2c_tgt_matcher.sv
module i2c_tgt_matcher
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REG_AW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  output logic              irq_o
);
  logic scl_lvl, sda_lvl, start_ev, stop_ev, rise_ev, fall_ev;
  logic [DATA_W-1:0] own_addr, rx_data;
  logic gc_en, nm_ie, new_match, data_wr, data_rd;
  logic pending, xmit, addressed, bus_busy, own_hit, gc_hit;
  logic ev_match, ev_stop, ev_nack;

  i2c_tgt_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_lvl), .sda_o(sda_lvl), .start_o(start_ev), .stop_o(stop_ev),
    .rise_o(rise_ev), .fall_o(fall_ev)
  );

  i2c_tgt_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_lvl), .start_i(start_ev), .stop_i(stop_ev),
    .rise_i(rise_ev), .fall_i(fall_ev), .own_addr_i(own_addr), .gc_en_i(gc_en),
    .data_wr_i(data_wr), .data_rd_i(data_rd), .wdata_i(reg_wdata_i),
    .rx_data_o(rx_data), .pending_o(pending), .xmit_o(xmit), .addressed_o(addressed),
    .bus_busy_o(bus_busy), .own_hit_o(own_hit), .gc_hit_o(gc_hit),
    .ev_match_o(ev_match), .ev_stop_o(ev_stop), .ev_nack_o(ev_nack),
    .scl_pull_o, .sda_pull_o
  );

  i2c_tgt_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .addr_i(reg_addr_i), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .rx_data_i(rx_data),
    .pending_i(pending), .xmit_i(xmit), .addressed_i(addressed), .bus_busy_i(bus_busy),
    .own_hit_i(own_hit), .gc_hit_i(gc_hit), .scl_lvl_i(scl_lvl), .sda_lvl_i(sda_lvl),
    .ev_match_i(ev_match), .ev_stop_i(ev_stop), .ev_nack_i(ev_nack),
    .own_addr_o(own_addr), .gc_en_o(gc_en), .nm_ie_o(nm_ie), .new_match_o(new_match),
    .data_wr_o(data_wr), .data_rd_o(data_rd), .irq_o
  );
endmodule

// File: rtl/i2c_tgt_matcher_chk.sv
module i2c_tgt_matcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_pull_i,
  input logic sda_pull_i,
  input logic irq_i,
  input logic pending_i,
  input logic addressed_i,
  input logic bus_busy_i,
  input logic own_hit_i,
  input logic gc_hit_i,
  input logic xmit_i,
  input logic new_match_i,
  input logic nm_ie_i
);
  AST_OWN_SETS_NEW_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_hit_i) |=> new_match_i); // R1
  AST_HIT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(own_hit_i && gc_hit_i)); // R2
  AST_GC_RECEIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_hit_i |-> !xmit_i); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addressed_i |-> (!scl_pull_i && !sda_pull_i)); // R4
  AST_NM_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nm_ie_i && new_match_i) |-> irq_i); // R5
  AST_STRETCH_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_i |-> pending_i); // R6
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_busy_i) |-> (!addressed_i && !own_hit_i && !gc_hit_i)); // R10
  AST_BUSY_IN_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addressed_i |-> bus_busy_i); // R11
endmodule

bind i2c_tgt_matcher i2c_tgt_matcher_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_pull_i(scl_pull_o), .sda_pull_i(sda_pull_o),
  .irq_i(irq_o), .pending_i(pending), .addressed_i(addressed), .bus_busy_i(bus_busy),
  .own_hit_i(own_hit), .gc_hit_i(gc_hit), .xmit_i(xmit), .new_match_i(new_match),
  .nm_ie_i(nm_ie)
);

// File: tb/i2c_tgt_matcher_test.sv
`timescale 1ns/100ps
module i2c_tgt_matcher_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull, irq;
  logic scl_line, sda_line;

  int total = 0, bad = 0;
  bit done = 0;

  // service performed while the target stretches SCL: 0 none, 1 read data, 2 write data
  int svc_kind = 0;
  logic [7:0] svc_wdata = '0, svc_rdata = '0;
  bit svc_hit = 0;

  always #2.5 clk = ~clk;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  i2c_tgt_matcher uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .scl_i(scl_line), .sda_i(sda_line), .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic clock_bit(input logic b, output logic r);
    logic [7:0] tmp;
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    if (!scl_line) begin
      svc_hit = 1;
      if (svc_kind == 1) begin reg_read(3'd0, tmp); svc_rdata = tmp; end
      else if (svc_kind == 2) reg_write(3'd0, svc_wdata);
      while (!scl_line) @(posedge clk);
      wq();
    end
    r = sda_line;
    scl_m = 1'b0; wq();
  endtask

  // master writes a byte; returns the ack level seen on the ninth clock
  task automatic write_byte(input logic [7:0] d, input int svc, output logic ack);
    logic r;
    svc_kind = 0; svc_hit = 0;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], r);
    svc_kind = svc;
    clock_bit(1'b1, ack);
    svc_kind = 0;
  endtask

  // master reads a byte, supplying svc_wdata to the host when stretched first
  task automatic read_byte(input logic [7:0] txd, input logic mack, output logic [7:0] d);
    logic r;
    svc_hit = 0; svc_wdata = txd; svc_kind = 2;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      d[i] = r;
      svc_kind = 0;
    end
    clock_bit(mack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic ack;
    logic [7:0] got;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R12 reset state
    reg_read(3'd1, v); chk("R12 status", v, 8'h00);
    reg_read(3'd2, v); chk("R12 line status", v, 8'h30);
    @(negedge clk);
    chk("R12 pulls irq", {scl_pull, sda_pull, irq}, 3'b000);

    reg_write(3'd4, 8'hC2);  // own address 0x42 enabled
    reg_write(3'd3, 8'h03);  // new-match irq, general call

    // write transfer
    bus_start();
    reg_read(3'd2, v); chk("R11 bus busy after START", v[1], 1'b1);
    write_byte(8'h84, 0, ack); chk("R1 address ack", ack, 1'b0);
    reg_read(3'd1, v); chk("R1 new match, receive", v[2:0], 3'b100);
    reg_read(3'd2, v); chk("R1 own hit, module busy", {v[3], v[2], v[0]}, 3'b011);
    @(negedge clk); chk("R5 irq on new match", irq, 1'b1);
    reg_write(3'd1, 8'h04);
    @(negedge clk); chk("R5 irq after clear", irq, 1'b0);
    reg_read(3'd1, v); chk("R5 new match cleared", v[2], 1'b0);
    write_byte(8'hA5, 1, ack);
    chk("R6 stretched", svc_hit, 1'b1);
    chk("R6 data 1", svc_rdata, 8'hA5);
    chk("R6 data ack", ack, 1'b0);
    write_byte(8'h3C, 1, ack);
    chk("R6 data 2", svc_rdata, 8'h3C);
    reg_read(3'd1, v); chk("R6 pending cleared", v[4], 1'b0);
    bus_stop();
    reg_read(3'd1, v); chk("R10 slave stop set", v[3], 1'b1);
    reg_read(3'd2, v); chk("R10 R11 idle after STOP", v[3:0], 4'b0000);
    reg_write(3'd1, 8'h08);
    reg_read(3'd1, v); chk("R10 slave stop cleared", v[3], 1'b0);

    // read transfer
    bus_start();
    write_byte(8'h85, 0, ack); chk("R1 read address ack", ack, 1'b0);
    reg_read(3'd1, v); chk("R1 transmit bit", v[0], 1'b1);
    reg_write(3'd1, 8'h04);
    read_byte(8'h96, 1'b0, got);
    chk("R7 stretched before byte", svc_hit, 1'b1);
    chk("R7 byte 1", got, 8'h96);
    read_byte(8'h5A, 1'b1, got);
    chk("R7 byte 2", got, 8'h5A);
    reg_read(3'd1, v); chk("R8 nack flag", v[1], 1'b1);
    @(negedge clk); chk("R8 SDA released", {scl_pull, sda_pull}, 2'b00);
    bus_stop();
    reg_read(3'd1, v); chk("R10 stop after nack", v[3], 1'b1);
    reg_write(3'd1, 8'h0A);

    // general call
    bus_start();
    write_byte(8'h00, 0, ack); chk("R2 general call ack", ack, 1'b0);
    reg_read(3'd2, v); chk("R2 gc hit only", v[3:2], 2'b10);
    reg_read(3'd1, v); chk("R2 receive mode", v[0], 1'b0);
    write_byte(8'h11, 1, ack); chk("R2 gc data", svc_rdata, 8'h11);
    bus_stop();
    reg_write(3'd1, 8'h0E);
    reg_write(3'd3, 8'h01);
    bus_start();
    write_byte(8'h00, 0, ack); chk("R2 gc disabled no ack", ack, 1'b1);
    bus_stop();
    reg_read(3'd1, v); chk("R10 no stop flag when not addressed", v[3:2], 2'b00);

    // non-matching address
    reg_write(3'd3, 8'h03);
    bus_start();
    write_byte(8'h20, 0, ack); chk("R4 no ack on mismatch", ack, 1'b1);
    reg_read(3'd2, v); chk("R4 not busy", v[0], 1'b0);
    write_byte(8'h00, 0, ack); chk("R4 later byte ignored", ack, 1'b1);
    @(negedge clk); chk("R4 lines released", {scl_pull, sda_pull}, 2'b00);
    bus_stop();

    // own-address enable clear
    reg_write(3'd4, 8'h42);
    bus_start();
    write_byte(8'h84, 0, ack); chk("R3 disabled own address", ack, 1'b1);
    bus_stop();
    reg_read(3'd1, v); chk("R3 no new match", v[2], 1'b0);
    reg_write(3'd4, 8'hC2);

    // repeated START
    bus_start();
    write_byte(8'h84, 0, ack);
    reg_write(3'd1, 8'h04);
    write_byte(8'h77, 1, ack); chk("R9 data before restart", svc_rdata, 8'h77);
    bus_rstart();
    write_byte(8'h85, 0, ack); chk("R9 ack after restart", ack, 1'b0);
    reg_read(3'd1, v); chk("R9 new match, no stop, transmit", {v[3], v[2], v[0]}, 3'b011);
    read_byte(8'hC3, 1'b1, got); chk("R9 read after restart", got, 8'hC3);
    bus_stop();
    reg_read(3'd1, v); chk("R10 stop after restart transfer", v[3], 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule